// File: doc/BRIEF.md
# Multi-Hart Load-Reserved / Store-Conditional Reservation Monitor

This block judges store-conditional operations for a group of harts. Each hart owns a small last-in-first-out stack of reserved addresses. A load-reserved pushes a 16-byte-aligned address onto the issuing hart's stack. A store-conditional passes only when the newest entry on that stack matches its own 16-byte-aligned address. Coherence invalidations from other agents arrive on a snoop port. They compare at cache-block granularity, using a mask supplied as a configuration input, and remove the newest entry of the addressed hart when it falls in the snooped block.

Every store-conditional returns a registered result code one cycle after the request. A per-hart counter tracks consecutive failures. Each time a hart's run of failures reaches a multiple of a fixed interval, a one-cycle warning pulse is raised together with that hart's index. Requests carry a hart index on every port. Within one cycle the three ports are applied in a fixed order: snoop, then store-conditional, then load-reserved.

Top module: `lrsc_monitor`

## Requirements
- R1: A load-reserved pushes its address with bits [3:0] forced to zero onto the stack of the hart it names. A hart can hold several reservations at once.
- R2: A store-conditional passes only if its hart's stack is non-empty and the newest entry equals the SC address with bits [3:0] forced to zero. Older entries are never consulted, and in every other case it fails.
- R3: One cycle after each store-conditional, `res_valid` is high, `res_hart` repeats the request's hart, and `res_code` is 0 for failure, 1 for success, or 2 for success with `sc_uncached` set. With no request, `res_valid` is low.
- R4: A passing store-conditional leaves the stack unchanged, so a repeat to the same 16-byte granule passes again.
- R5: A snoop on a hart with an empty stack does nothing. Otherwise the snoop address and the newest entry are both ANDed with `cblk_mask`, and the newest entry is removed only when they are equal. Deeper entries are never examined.
- R6: The stack holds `DEPTH` entries. A load-reserved onto a full stack drops the oldest entry and keeps the new one.
- R7: When ports target the same hart in one cycle, the snoop acts first. The store-conditional is then judged against the stack after the snoop, and the load-reserved is pushed after that judgment.
- R8: Each failing store-conditional adds one to its hart's consecutive-failure count. When the count reaches a multiple of `WARN_INTERVAL` (default 10000), `warn_pulse` is high for one cycle, aligned with that result, and `warn_hart` gives the hart.
- R9: A passing store-conditional restarts its hart's consecutive-failure count from zero.
- R10: Synchronous reset empties every stack, clears every failure count and drives `res_valid` and `warn_pulse` low.
- R11: Stacks and counters of different harts are independent. A request for one hart never changes another hart's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cblk_mask | input | ADDR_W | Cache-block mask; set bits are compared on snoops |
| lr_valid | input | 1 | Load-reserved request |
| lr_hart | input | HART_W | Hart of the load-reserved |
| lr_addr | input | ADDR_W | Physical address of the load-reserved |
| sc_valid | input | 1 | Store-conditional request |
| sc_hart | input | HART_W | Hart of the store-conditional |
| sc_addr | input | ADDR_W | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional access is uncacheable |
| snp_valid | input | 1 | Coherence invalidation |
| snp_hart | input | HART_W | Hart whose reservations the snoop hits |
| snp_addr | input | ADDR_W | Snooped address |
| res_valid | output | 1 | Result of the previous cycle's store-conditional |
| res_hart | output | HART_W | Hart of that result |
| res_code | output | 2 | 0 fail, 1 pass, 2 pass uncacheable |
| warn_pulse | output | 1 | Failure-interval warning |
| warn_hart | output | HART_W | Hart that reached the interval |

## Verification
The bench targets the same-cycle orderings. A design that judged a store-conditional before a simultaneous snoop, or after a simultaneous load-reserved, would report a pass where a fail is due. It fills a stack beyond its depth and then drains it with snoops: dropping the new entry instead of the oldest, or wrapping the count, makes the final store-conditionals pass or fail wrongly. Store-conditionals that hit an older, non-top reservation must fail, and snoops that match only a deeper entry must not pop. Runs of ten thousand failures, both before and after a success, expose a counter that is not cleared or that pulses one failure early or late.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int GRANULE_BITS = 4;

    typedef enum logic [1:0] {
        SC_FAIL        = 2'd0,
        SC_PASS        = 2'd1,
        SC_PASS_UNCACH = 2'd2
    } sc_code_e;

    // Mask covering the 16-byte reservation granule, applied to any width up to 64.
    function automatic logic [63:0] granule_of(input logic [63:0] a);
        return a & ~((64'd1 << GRANULE_BITS) - 64'd1);
    endfunction

    function automatic sc_code_e pick_code(input logic pass, input logic uncached);
        if (!pass)
            return SC_FAIL;
        else if (uncached)
            return SC_PASS_UNCACH;
        else
            return SC_PASS;
    endfunction

endpackage

// File: rtl/rsv_stack.sv
module rsv_stack #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] top_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic [CNT_W-1:0]  count
);

    logic [ADDR_W-1:0] ent [DEPTH];

    assign top_addr = ent[0];

    generate
        if (DEPTH > 1) begin : g_next
            assign next_addr = ent[1];
        end else begin : g_no_next
            assign next_addr = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (push && pop) begin
            // Newest entry replaced; depth unchanged.
            ent[0] <= push_addr;
        end else if (push) begin
            for (int i = DEPTH - 1; i > 0; i--) ent[i] <= ent[i-1];
            ent[0] <= push_addr;
            if (count != CNT_W'(DEPTH)) count <= count + 1'b1;
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/fail_counter.sv
module fail_counter #(
    parameter int WARN_INTERVAL = 10000,
    localparam int CW = (WARN_INTERVAL > 1) ? $clog2(WARN_INTERVAL) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fail,
    input  logic clear,
    output logic hit
);

    logic [CW-1:0] run;
    logic          at_last;

    assign at_last = (run == CW'(WARN_INTERVAL - 1));
    assign hit     = fail && at_last;

    always_ff @(posedge clk) begin
        if (rst || clear)
            run <= '0;
        else if (fail)
            run <= at_last ? '0 : run + 1'b1;
    end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int NUM_HARTS     = 4,
    parameter int ADDR_W        = 32,
    parameter int DEPTH         = 4,
    parameter int WARN_INTERVAL = 10000,
    localparam int HART_W       = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
    localparam int CNT_W        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cblk_mask,
    input  logic              lr_valid,
    input  logic [HART_W-1:0] lr_hart,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_valid,
    input  logic [HART_W-1:0] sc_hart,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              sc_uncached,
    input  logic              snp_valid,
    input  logic [HART_W-1:0] snp_hart,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              res_valid,
    output logic [HART_W-1:0] res_hart,
    output logic [1:0]        res_code,
    output logic              warn_pulse,
    output logic [HART_W-1:0] warn_hart
);

    logic [ADDR_W-1:0] lr_gran, sc_gran;
    assign lr_gran = ADDR_W'(granule_of(64'(lr_addr)));
    assign sc_gran = ADDR_W'(granule_of(64'(sc_addr)));

    logic [NUM_HARTS-1:0] pop_v, push_v, pass_v, fail_v, clr_v, warn_v;

    generate
        for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
            logic [ADDR_W-1:0] top_a, next_a, view_top;
            logic [CNT_W-1:0]  cnt;
            logic              view_full;

            rsv_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_stk (
                .clk       (clk),
                .rst       (rst),
                .push      (push_v[h]),
                .push_addr (lr_gran),
                .pop       (pop_v[h]),
                .top_addr  (top_a),
                .next_addr (next_a),
                .count     (cnt)
            );

            // Snoop stage: newest entry only, compared at block granularity.
            assign pop_v[h] = snp_valid && (snp_hart == HART_W'(h)) && (cnt != '0)
                              && ((top_a & cblk_mask) == (snp_addr & cblk_mask));

            // Stack as seen by a store-conditional in the same cycle.
            assign view_full = pop_v[h] ? (cnt > CNT_W'(1)) : (cnt != '0);
            assign view_top  = pop_v[h] ? next_a : top_a;

            assign pass_v[h] = sc_valid && (sc_hart == HART_W'(h)) && view_full
                               && (view_top == sc_gran);
            assign fail_v[h] = sc_valid && (sc_hart == HART_W'(h)) && !pass_v[h];
            assign clr_v[h]  = pass_v[h];
            assign push_v[h] = lr_valid && (lr_hart == HART_W'(h));

            fail_counter #(.WARN_INTERVAL(WARN_INTERVAL)) u_fc (
                .clk   (clk),
                .rst   (rst),
                .fail  (fail_v[h]),
                .clear (clr_v[h]),
                .hit   (warn_v[h])
            );
        end
    endgenerate

    sc_code_e code_d;
    assign code_d = pick_code(|pass_v, sc_uncached);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_hart   <= '0;
            res_code   <= SC_FAIL;
            warn_pulse <= 1'b0;
            warn_hart  <= '0;
        end else begin
            res_valid  <= sc_valid;
            res_hart   <= sc_hart;
            res_code   <= sc_valid ? code_d : SC_FAIL;
            warn_pulse <= |warn_v;
            warn_hart  <= sc_hart;
        end
    end

endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int HART_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sc_valid,
    input logic [HART_W-1:0] sc_hart,
    input logic              sc_uncached,
    input logic              res_valid,
    input logic [HART_W-1:0] res_hart,
    input logic [1:0]        res_code,
    input logic              warn_pulse,
    input logic [HART_W-1:0] warn_hart
);

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        sc_valid |=> res_valid && res_hart == $past(sc_hart)); // R3

    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
        !sc_valid |=> !res_valid && !warn_pulse); // R3

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_code != 2'd3); // R3

    AST_PASS_KIND: assert property (@(posedge clk) disable iff (rst)
        sc_valid ##1 (res_code != 2'd0) |-> res_code == ($past(sc_uncached) ? 2'd2 : 2'd1)); // R3

    AST_WARN_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
        warn_pulse |-> res_valid && res_code == 2'd0 && warn_hart == res_hart); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !res_valid && !warn_pulse); // R10

endmodule

bind lrsc_monitor lrsc_monitor_chk #(.HART_W(HART_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sc_valid    (sc_valid),
    .sc_hart     (sc_hart),
    .sc_uncached (sc_uncached),
    .res_valid   (res_valid),
    .res_hart    (res_hart),
    .res_code    (res_code),
    .warn_pulse  (warn_pulse),
    .warn_hart   (warn_hart)
);

// File: tb/lrsc_monitor_tb.sv
`timescale 1ns/1ps
module lrsc_monitor_tb;

    localparam int NH     = 4;
    localparam int AW     = 32;
    localparam int DEPTH  = 4;
    localparam int WINT   = 10000;
    localparam int HW     = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] cblk_mask;
    logic          lr_valid, sc_valid, sc_uncached, snp_valid;
    logic [HW-1:0] lr_hart, sc_hart, snp_hart;
    logic [AW-1:0] lr_addr, sc_addr, snp_addr;
    logic          res_valid, warn_pulse;
    logic [HW-1:0] res_hart, warn_hart;
    logic [1:0]    res_code;

    always #4 clk = ~clk; // 125 MHz

    lrsc_monitor #(.NUM_HARTS(NH), .ADDR_W(AW), .DEPTH(DEPTH), .WARN_INTERVAL(WINT)) u_dut (
        .clk(clk), .rst(rst), .cblk_mask(cblk_mask),
        .lr_valid(lr_valid), .lr_hart(lr_hart), .lr_addr(lr_addr),
        .sc_valid(sc_valid), .sc_hart(sc_hart), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
        .snp_valid(snp_valid), .snp_hart(snp_hart), .snp_addr(snp_addr),
        .res_valid(res_valid), .res_hart(res_hart), .res_code(res_code),
        .warn_pulse(warn_pulse), .warn_hart(warn_hart)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int warn_seen = 0;

    // Reference model state
    logic [AW-1:0] bstk [NH][DEPTH];
    int            bcnt [NH];
    int            bfail[NH];

    function automatic logic [AW-1:0] gran(input logic [AW-1:0] a);
        return a & ~32'hF;
    endfunction

    task automatic model_reset();
        for (int h = 0; h < NH; h++) begin
            bcnt[h] = 0;
            bfail[h] = 0;
            for (int i = 0; i < DEPTH; i++) bstk[h][i] = '0;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model in order snoop -> SC -> LR, check at next negedge.
    task automatic step(input string tag,
                        input bit lv, input int lh, input logic [AW-1:0] la,
                        input bit sv, input int sh, input logic [AW-1:0] sa, input bit su,
                        input bit nv, input int nh, input logic [AW-1:0] na);
        bit  pass, ew;
        logic [1:0] ec;
        lr_valid = lv; lr_hart = HW'(lh); lr_addr = la;
        sc_valid = sv; sc_hart = HW'(sh); sc_addr = sa; sc_uncached = su;
        snp_valid = nv; snp_hart = HW'(nh); snp_addr = na;
        if (nv && bcnt[nh] > 0 && ((bstk[nh][0] & cblk_mask) == (na & cblk_mask))) begin
            for (int i = 0; i < DEPTH - 1; i++) bstk[nh][i] = bstk[nh][i+1];
            bcnt[nh]--;
        end
        pass = 0; ew = 0; ec = 2'd0;
        if (sv) begin
            pass = (bcnt[sh] > 0) && (bstk[sh][0] == gran(sa));
            if (pass) begin
                ec = su ? 2'd2 : 2'd1;
                bfail[sh] = 0;
            end else begin
                bfail[sh]++;
                ew = (bfail[sh] % WINT) == 0;
            end
        end
        if (lv) begin
            for (int i = DEPTH - 1; i > 0; i--) bstk[lh][i] = bstk[lh][i-1];
            bstk[lh][0] = gran(la);
            if (bcnt[lh] < DEPTH) bcnt[lh]++;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, {29'd0, res_valid, res_code}, {29'd0, sv, ec});
        if (sv) check(tag, 32'(res_hart), 32'(sh));
        check(tag, {31'd0, warn_pulse}, {31'd0, ew});
        if (ew) check(tag, 32'(warn_hart), 32'(sh));
        if (warn_pulse) warn_seen++;
    endtask

    task automatic idle(); step("idle", 0,0,0, 0,0,0,0, 0,0,0); endtask
    task automatic lr(input string t, input int h, input logic [AW-1:0] a);
        step(t, 1,h,a, 0,0,0,0, 0,0,0);
    endtask
    task automatic sc(input string t, input int h, input logic [AW-1:0] a, input bit u);
        step(t, 0,0,0, 1,h,a,u, 0,0,0);
    endtask
    task automatic snp(input string t, input int h, input logic [AW-1:0] a);
        step(t, 0,0,0, 0,0,0,0, 1,h,a);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        lr_valid = 0; sc_valid = 0; snp_valid = 0; sc_uncached = 0;
        lr_hart = 0; sc_hart = 0; snp_hart = 0; lr_addr = 0; sc_addr = 0; snp_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ws;
        void'($urandom(32'd2718));
        cblk_mask = ~32'h3F; // 64-byte blocks
        do_reset();
        // R10: outputs quiet after reset, stacks empty
        check("R10 reset res_valid", {31'd0, res_valid}, 32'd0);
        check("R10 reset warn", {31'd0, warn_pulse}, 32'd0);
        sc("R10 empty stack fails", 0, 32'h100, 0);

        // R1, R2, R3, R4
        lr("R1 push", 1, 32'h1237);
        sc("R1 granule match", 1, 32'h1230, 0);
        sc("R4 repeat passes", 1, 32'h123C, 0);
        sc("R3 uncached code 2", 1, 32'h1238, 1);
        sc("R2 other granule fails", 1, 32'h1240, 0);
        lr("R1 second reservation", 1, 32'h2000);
        sc("R2 older entry not used", 1, 32'h1230, 0);
        sc("R2 top passes", 1, 32'h2004, 0);

        // R5
        snp("R5 empty hart snoop", 2, 32'h2000);
        snp("R5 miss keeps top", 1, 32'h1230);
        sc("R5 top still present", 1, 32'h2000, 0);
        snp("R5 block match pops", 1, 32'h2030);
        sc("R5 older entry now top", 1, 32'h1230, 0);
        sc("R5 popped entry gone", 1, 32'h2000, 0);

        // R11
        sc("R11 other hart fails", 0, 32'h1230, 0);
        lr("R11 hart0 push", 0, 32'h5000);
        sc("R11 hart1 unaffected", 1, 32'h1230, 0);

        // R6: overfill hart 3
        for (int i = 0; i <= DEPTH; i++) lr("R6 fill", 3, 32'h8000 + 32'(i) * 32'h400);
        for (int i = DEPTH; i > 1; i--) snp("R6 drain", 3, 32'h8000 + 32'(i) * 32'h400);
        sc("R6 oldest kept entry", 3, 32'h8400, 0);
        snp("R6 drain last", 3, 32'h8400);
        sc("R6 dropped entry absent", 3, 32'h8000, 0);

        // R7: same-cycle ordering on hart 2
        lr("R7 setup", 2, 32'h9000);
        step("R7 snoop before SC", 0,0,0, 1,2,32'h9000,0, 1,2,32'h9010);
        step("R7 SC before LR", 1,2,32'hA000, 1,2,32'hA000,0, 0,0,0);
        sc("R7 LR applied after", 2, 32'hA000, 0);
        step("R7 snoop pop then push", 1,2,32'hB000, 0,0,0,0, 1,2,32'hA000);
        sc("R7 pushed survives", 2, 32'hB000, 0);
        snp("R7 clear", 2, 32'hB000);

        // R8: long run of failures on hart 2
        do_reset();
        ws = warn_seen;
        for (int i = 0; i < WINT + 5; i++) sc("R8 fail run", 2, 32'hC000, 0);
        check("R8 one warn per interval", 32'(warn_seen - ws), 32'd1);

        // R9: success restarts count
        lr("R9 setup", 2, 32'hC000);
        sc("R9 pass clears", 2, 32'hC000, 0);
        snp("R9 drop", 2, 32'hC000);
        ws = warn_seen;
        for (int i = 0; i < WINT - 1; i++) sc("R9 no early warn", 2, 32'hC000, 0);
        check("R9 no warn before interval", 32'(warn_seen - ws), 32'd0);
        sc("R9 warn at interval", 2, 32'hC000, 0);
        check("R9 warn after interval", 32'(warn_seen - ws), 32'd1);

        // R10: mid-run reset clears reservations
        lr("R10 pre-reset", 0, 32'hD000);
        do_reset();
        sc("R10 reservation cleared", 0, 32'hD000, 0);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            bit lv, sv, nv, su;
            int lh, sh, nh;
            logic [AW-1:0] la, sa, na;
            lv = ($urandom % 3) == 0; sv = ($urandom % 2) == 0; nv = ($urandom % 4) == 0;
            su = ($urandom % 4) == 0;
            lh = $urandom % NH; sh = $urandom % NH; nh = $urandom % NH;
            la = 32'h4000 + 32'($urandom % 16) * 32'h10 + 32'($urandom % 16);
            sa = 32'h4000 + 32'($urandom % 16) * 32'h10 + 32'($urandom % 16);
            na = 32'h4000 + 32'($urandom % 16) * 32'h10;
            step("R2 R5 R7 random", lv,lh,la, sv,sh,sa,su, nv,nh,na);
        end
        idle();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule